// File: doc/BRIEF.md
# Pipelined Mersenne Twister Uniform Generator

This block produces a stream of 32-bit pseudorandom words with a period of 2^19937 - 1. A single 32-bit seed is expanded into a pool of 624 state words, writing one word per clock. After that, a twist pipeline updates one pool word per clock. A tempering pipeline works alongside the twist and turns each freshly updated word into an output value. In steady state the block delivers one new word every clock.

The twist needs three pool words for every step. A dual-port memory gives only one read and one write per cycle, so the pool is kept in three identical memories. Each memory serves one operand, and every new word is written to all three.

The output is a valid/take handshake. A word is consumed on a clock edge where both `word_valid` and `take` are high. While `take` is low the pipeline holds its data. A seed load is accepted at any time. It aborts the stream and restarts initialization.

Top module: `mersenne_twist_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first seed load, `ready` and `word_valid` are low.
- R2: On the clock after `seed_load` is sampled high, `ready` and `word_valid` are low, whatever the block was doing before.
- R3: The pool is filled as follows: word 0 is the seed, and word k = (1812433253 × (w ^ (w >> 30)) + k) mod 2^32, where w is word k-1, for k = 1..623. `ready` goes high on the 623rd rising edge after the edge that sampled `seed_load`.
- R4: Twist steps run in order for i = 0, 1, 2, ... with indices taken mod 624. Each step forms y = (word[i] & 0x80000000) | (word[i+1] & 0x7FFFFFFF). It then sets word[i] = word[i+397] ^ (y >> 1) ^ (y bit 0 ? 0x9908B0DF : 0).
- R5: Each output is the newly written word x after tempering, applied in this order: x ^= x >> 11; x ^= (x << 7) & 0x9D2C5680; x ^= (x << 15) & 0xEFC60000; x ^= x >> 18.
- R6: For seed 5489 the first accepted word is 3499211612 and the 10000th is 4123659995.
- R7: With `take` held high, once `word_valid` is high it stays high on every following clock until the next seed load.
- R8: While `take` is low, `word_valid` and `word_out` hold their values. No word is lost or skipped across a stall.
- R9: `word_valid` is never high while `ready` is low.
- R10: A seed load in the middle of a stream, or during initialization, restarts the sequence of the new seed from its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Strobe: start initialization from `seed_in` |
| seed_in | input | 32 | Seed value |
| take | input | 1 | Consumer accepts `word_out` on this edge |
| ready | output | 1 | Pool initialized, generator running |
| word_valid | output | 1 | `word_out` holds an unconsumed word |
| word_out | output | 32 | Tempered random word |

## Verification
The stream is compared word by word against a behavioural model for several seeds, including 5489, 0, 1 and 0xDEADBEEF. Seed 5489 anchors the model to two published values, so the model and the design cannot share the same mistake. A run of 10000 words crosses the pool boundary many times, which separates a correct i+1 and i+397 wrap from an off-by-one. One stall pattern keeps `take` high continuously and another lowers it one clock in three; together they distinguish a correct hold from a dropped or repeated word. Reloads during initialization and in mid-stream show whether stale pipeline contents leak into the new sequence.

// File: rtl/mersenne_twist_gen.sv
module mersenne_twist_gen #(
  parameter int          N        = 624,
  parameter int          M        = 397,
  parameter logic [31:0] TWIST_K  = 32'h9908B0DF,
  parameter logic [31:0] INIT_MUL = 32'd1812433253,
  parameter logic [31:0] TMASK_B  = 32'h9D2C5680,
  parameter logic [31:0] TMASK_C  = 32'hEFC60000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed_load,
  input  logic [31:0] seed_in,
  input  logic        take,
  output logic        ready,
  output logic        word_valid,
  output logic [31:0] word_out
);
  localparam int             AW     = $clog2(N);
  localparam logic [AW-1:0]  LAST   = AW'(N - 1);
  localparam logic [AW-1:0]  WRAP_M = AW'(N - M);
  localparam logic [AW-1:0]  OFF_M  = AW'(M);

  typedef enum logic [1:0] {IDLE, INIT, RUN} phase_t;
  phase_t phase;

  logic [AW-1:0] cnt, idx, ia1, ia2, waddr;
  logic [AW-1:0] ra [3];
  logic [31:0]   rd [3];
  logic [31:0]   prev, init_val, y, nw_c, nw, t1, t2, tb, tc, wdata;
  logic [4:0]    vp;
  logic          adv, we;

  assign ready      = (phase == RUN);
  assign word_valid = vp[4];
  assign adv        = ready && (take || !word_valid) && !seed_load;

  always_comb begin
    ra[0] = idx;
    ra[1] = (idx == LAST) ? '0 : idx + AW'(1);
    ra[2] = (idx >= WRAP_M) ? idx - WRAP_M : idx + OFF_M;
  end

  assign init_val = INIT_MUL * (prev ^ (prev >> 30)) + 32'(cnt);
  assign we    = seed_load || (phase == INIT) || (adv && vp[1]);
  assign waddr = seed_load ? '0 : (phase == INIT) ? cnt : ia2;
  assign wdata = seed_load ? seed_in : (phase == INIT) ? init_val : nw;

  for (genvar c = 0; c < 3; c++) begin : g_copy
    logic [31:0] mem [N];
    logic [31:0] q;
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (adv) q <= (we && waddr == ra[c]) ? wdata : mem[ra[c]];
    end
    assign rd[c] = q;
  end

  assign y    = {rd[0][31], rd[1][30:0]};
  assign nw_c = rd[2] ^ (y >> 1) ^ (y[0] ? TWIST_K : 32'd0);
  assign tb   = t1 ^ ((t1 << 7) & TMASK_B);
  assign tc   = tb ^ ((tb << 15) & TMASK_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= IDLE;
      cnt   <= '0;
      prev  <= '0;
      idx   <= '0;
      ia1   <= '0;
      ia2   <= '0;
      vp    <= '0;
    end else if (seed_load) begin
      phase <= INIT;
      cnt   <= AW'(1);
      prev  <= seed_in;
      idx   <= '0;
      vp    <= '0;
    end else begin
      if (phase == INIT) begin
        prev <= init_val;
        cnt  <= cnt + AW'(1);
        if (cnt == LAST) phase <= RUN;
      end
      if (adv) begin
        vp  <= {vp[3:0], 1'b1};
        idx <= ra[1];
        ia1 <= idx;
        ia2 <= ia1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      nw       <= nw_c;
      t1       <= nw ^ (nw >> 11);
      t2       <= tc;
      word_out <= t2 ^ (t2 >> 18);
    end
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> !ready && !word_valid);

  a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> !ready && !word_valid);

  a_r7_steady_stream: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && take && !seed_load |=> word_valid);

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !take && !seed_load |=> word_valid && $stable(word_out));

  a_r9_valid_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> ready);

endmodule

// File: tb/test_mersenne_twist_gen.sv
module test_mersenne_twist_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_load = 1'b0;
  logic [31:0] seed_in = '0;
  logic        take = 1'b0;
  logic        ready, word_valid;
  logic [31:0] word_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [31:0] mt [624];
  int          pos;

  mersenne_twist_gen i_mersenne_twist_gen (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_in(seed_in),
    .take(take), .ready(ready), .word_valid(word_valid), .word_out(word_out)
  );

  always #2ns clk = ~clk;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cycles, 150000);
      report();
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic model_seed(input logic [31:0] s);
    mt[0] = s;
    for (int k = 1; k < 624; k++)
      mt[k] = 32'd1812433253 * (mt[k-1] ^ (mt[k-1] >> 30)) + 32'(k);
    pos = 0;
  endtask

  task automatic model_next(output logic [31:0] r);
    logic [31:0] yv, x;
    yv = (mt[pos] & 32'h80000000) | (mt[(pos + 1) % 624] & 32'h7FFFFFFF);
    mt[pos] = mt[(pos + 397) % 624] ^ (yv >> 1) ^ (yv[0] ? 32'h9908B0DF : 32'd0);
    x = mt[pos];
    x = x ^ (x >> 11);
    x = x ^ ((x << 7) & 32'h9D2C5680);
    x = x ^ ((x << 15) & 32'hEFC60000);
    x = x ^ (x >> 18);
    pos = (pos + 1) % 624;
    r = x;
  endtask

  task automatic load_seed(input logic [31:0] s, input logic wait_ready);
    int n;
    @(negedge clk);
    seed_in   = s;
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    check(!ready && !word_valid, "R2 flags low after load", {30'd0, ready, word_valid}, 32'd0);
    model_seed(s);
    if (wait_ready) begin
      n = 0;
      while (!ready) begin
        @(negedge clk);
        n++;
      end
      check(n == 623, "R3 init length", n, 623);
    end
  endtask

  task automatic consume(input int count, input bit stall, output logic [31:0] last);
    int got = 0;
    int t = 0;
    bit seen = 0;
    bit held = 0;
    logic [31:0] hold_w = '0;
    logic [31:0] exp;
    while (got < count) begin
      @(negedge clk);
      if (held)
        check(word_valid && word_out == hold_w, "R8 hold during stall", word_out, hold_w);
      take = stall ? (t % 3 != 1) : 1'b1;
      t++;
      if (word_valid && !ready)
        check(0, "R9 valid without ready", {31'd0, ready}, 32'd1);
      if (!stall && seen)
        check(word_valid, "R7 one word per clock", {31'd0, word_valid}, 32'd1);
      held = word_valid && !take;
      hold_w = word_out;
      if (word_valid && take) begin
        model_next(exp);
        check(word_out == exp, "R4 R5 R10 stream word", word_out, exp);
        last = word_out;
        got++;
        seen = 1;
      end
    end
  endtask

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    check(!ready && !word_valid, "R1 reset flags", {30'd0, ready, word_valid}, 32'd0);
    rst_n = 1'b1;
    take  = 1'b1;
    repeat (5) @(negedge clk);
    check(!ready && !word_valid, "R1 idle without seed", {30'd0, ready, word_valid}, 32'd0);

    load_seed(32'd5489, 1'b1);
    consume(1, 1'b0, w);
    check(w == 32'd3499211612, "R6 first word seed 5489", w, 32'd3499211612);
    consume(9999, 1'b0, w);
    check(w == 32'd4123659995, "R6 10000th word seed 5489", w, 32'd4123659995);

    consume(300, 1'b1, w);

    load_seed(32'd0, 1'b1);
    consume(700, 1'b0, w);

    take = 1'b0;
    repeat (10) @(negedge clk);
    load_seed(32'hDEADBEEF, 1'b1);
    consume(400, 1'b1, w);

    load_seed(32'd77, 1'b0);
    repeat (100) @(negedge clk);
    load_seed(32'd1, 1'b1);
    consume(1300, 1'b0, w);

    report();
  end
endmodule